// File: doc/BRIEF.md
# First Uncorrectable Scrub Error Logger

This block sits beside a periodic memory scrubber and keeps the cache-line address of the first uncorrectable error the scrubber reports. Each report arrives as a one-cycle strobe with a system address. The block captures the address only when that report becomes the first error since software last cleared the first-error flag. Later reports leave the address alone and only raise a next-error flag.

The logged address and both flags are sticky. An ordinary system reset leaves them unchanged, so software can read the log after a warm restart. Only the power-good reset returns them to zero. Software reaches the block through a small register port. One register holds the two flags, and each flag is cleared by writing 1 to its bit. The other register is a read-only view of the logged address. Read data is registered and has one cycle of latency.

Top module: `scrub_err_logger`

## Requirements
- R1: An error strobe while the first-error flag is clear sets the first-error flag and captures system address bits 34:6 into the logged field on the same clock edge.
- R2: An error strobe while the first-error flag is set, with no concurrent clear of that flag, sets the next-error flag and leaves the logged field unchanged.
- R3: A write with regSel=0 clears the first-error flag when regWrData bit 0 is 1, and clears the next-error flag when regWrData bit 1 is 1. Clearing the first-error flag re-arms capture.
- R4: When an error strobe and a clear of the first-error flag fall in the same cycle, the error wins. The first-error flag stays set and the new address is captured.
- R5: With regSel=1 the read data shows the logged field in bits 30:2, with bits 31 and 1:0 zero. With regSel=0 it shows the first-error flag in bit 0, the next-error flag in bit 1, and zeros in all other bits.
- R6: Writes with regSel=1 have no effect on the logged field or on the flags.
- R7: Holding rstN low leaves the logged field and both flags unchanged and forces the read data to zero.
- R8: Holding pgRstN low clears the logged field, both flags and the read data to zero. It takes priority over every other input.
- R9: logValid is high exactly when the first-error flag or the next-error flag is set.
- R10: The flags and the logged field change on the clock edge that samples the strobe or the write. Read data reflects the state before that edge, one cycle after regSel is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pgRstN | input | 1 | Power-good reset, synchronous, active low; clears everything |
| rstN | input | 1 | System reset, synchronous, active low; clears read data only |
| errValid | input | 1 | One-cycle strobe: uncorrectable error found by the scrubber |
| errAddr | input | 35 | System address of the failing line |
| regSel | input | 1 | Register select: 0 status flags, 1 logged address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data for the selected register |
| logField | output | 29 | Logged address bits 34:6 |
| logValid | output | 1 | Logged address is meaningful |
| firstErr | output | 1 | First-error flag |
| nextErr | output | 1 | Next-error flag |

## Verification
A wrong flag state shows up at the ports on the very next edge. A missed capture leaves logField stale, and a spurious capture overwrites it with the second error's address, so both are seen one cycle after the strobe. A reset wired to the wrong domain is exposed right after a system reset pulse, when logField or the flags read back as zero although they should have kept their values. The same-cycle clear-and-error case and the write to the read-only register are driven directly, because a wrong priority would otherwise stay hidden until a much later error.

// File: rtl/scrub_log_pkg.sv
package scrub_log_pkg;
  // Strobes and flag levels passed from control to datapath
  typedef struct packed {
    logic capture;
    logic firstLvl;
    logic nextLvl;
  } strobe_t;
endpackage

// File: rtl/scrub_log_ctrl.sv
module scrub_log_ctrl
  import scrub_log_pkg::*;
(
  input  logic       clk,
  input  logic       pgRstN,
  input  logic       errValid,
  input  logic       stsWrEn,
  input  logic [1:0] stsWrBits,
  output strobe_t    stb
);
  logic firstQ, nextQ;
  logic clrFirst, clrNext, captureEn, setNext;

  assign clrFirst  = stsWrEn && stsWrBits[0];
  assign clrNext   = stsWrEn && stsWrBits[1];
  assign captureEn = errValid && (!firstQ || clrFirst);
  assign setNext   = errValid && firstQ && !clrFirst;

  always_ff @(posedge clk) begin
    if (!pgRstN) begin
      firstQ <= 1'b0;
      nextQ  <= 1'b0;
    end else begin
      if (captureEn)     firstQ <= 1'b1;
      else if (clrFirst) firstQ <= 1'b0;
      if (setNext)       nextQ  <= 1'b1;
      else if (clrNext)  nextQ  <= 1'b0;
    end
  end

  always_comb begin
    stb.capture  = captureEn;
    stb.firstLvl = firstQ;
    stb.nextLvl  = nextQ;
  end

  // R1
  first_set_chk: assert property (@(posedge clk) disable iff (!pgRstN)
    (errValid && !firstQ) |=> firstQ);
  // R2
  next_set_chk: assert property (@(posedge clk) disable iff (!pgRstN)
    (errValid && firstQ && !clrFirst) |=> nextQ);
  // R4
  clr_race_chk: assert property (@(posedge clk) disable iff (!pgRstN)
    (errValid && clrFirst) |=> firstQ);
  // R3
  clr_first_chk: assert property (@(posedge clk) disable iff (!pgRstN)
    (clrFirst && !errValid) |=> !firstQ);
endmodule

// File: rtl/scrub_log_dp.sv
module scrub_log_dp
  import scrub_log_pkg::*;
#(
  parameter int SYS_ADDR_W = 35,
  parameter int LINE_LSB   = 6,
  parameter int REG_W      = 32,
  parameter int FIELD_LSB  = 2,
  localparam int FIELD_W   = SYS_ADDR_W - LINE_LSB
) (
  input  logic                  clk,
  input  logic                  pgRstN,
  input  logic                  rstN,
  input  logic [SYS_ADDR_W-1:0] errAddr,
  input  logic                  regSel,
  input  strobe_t               stb,
  output logic [FIELD_W-1:0]    logField,
  output logic [REG_W-1:0]      rdData
);
  logic [REG_W-1:0] addrView, statusView;

  always_ff @(posedge clk) begin
    if (!pgRstN)          logField <= '0;
    else if (stb.capture) logField <= errAddr[SYS_ADDR_W-1:LINE_LSB];
  end

  always_comb begin
    addrView = '0;
    addrView[FIELD_LSB +: FIELD_W] = logField;
    statusView = '0;
    statusView[0] = stb.firstLvl;
    statusView[1] = stb.nextLvl;
  end

  always_ff @(posedge clk) begin
    if (!pgRstN || !rstN) rdData <= '0;
    else                  rdData <= regSel ? addrView : statusView;
  end

  // R2
  hold_field_chk: assert property (@(posedge clk) disable iff (!pgRstN)
    !stb.capture |=> $stable(logField));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!pgRstN)
    !rstN |=> (rdData == '0));
endmodule

// File: rtl/scrub_err_logger.sv
module scrub_err_logger
  import scrub_log_pkg::*;
#(
  parameter int SYS_ADDR_W = 35,
  parameter int LINE_LSB   = 6,
  parameter int REG_W      = 32,
  parameter int FIELD_LSB  = 2,
  localparam int FIELD_W   = SYS_ADDR_W - LINE_LSB
) (
  input  logic                  clk,
  input  logic                  pgRstN,
  input  logic                  rstN,
  input  logic                  errValid,
  input  logic [SYS_ADDR_W-1:0] errAddr,
  input  logic                  regSel,
  input  logic                  regWrEn,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  output logic [FIELD_W-1:0]    logField,
  output logic                  logValid,
  output logic                  firstErr,
  output logic                  nextErr
);
  strobe_t stb;

  scrub_log_ctrl u_ctrl (
    .clk(clk), .pgRstN(pgRstN), .errValid(errValid),
    .stsWrEn(regWrEn && !regSel), .stsWrBits(regWrData[1:0]), .stb(stb)
  );

  scrub_log_dp #(
    .SYS_ADDR_W(SYS_ADDR_W), .LINE_LSB(LINE_LSB),
    .REG_W(REG_W), .FIELD_LSB(FIELD_LSB)
  ) u_dp (
    .clk(clk), .pgRstN(pgRstN), .rstN(rstN), .errAddr(errAddr),
    .regSel(regSel), .stb(stb), .logField(logField), .rdData(regRdData)
  );

  assign firstErr = stb.firstLvl;
  assign nextErr  = stb.nextLvl;
  assign logValid = stb.firstLvl || stb.nextLvl;

  // R6
  ro_addr_chk: assert property (@(posedge clk) disable iff (!pgRstN)
    (regWrEn && regSel && !errValid) |=> ($stable(logField) && $stable(firstErr) && $stable(nextErr)));
endmodule

// File: tb/sim_scrub_err_logger.sv
`timescale 1ns/1ps
module sim_scrub_err_logger;
  logic        clk = 1'b0;
  logic        pgRstN = 1'b0, rstN = 1'b0;
  logic        errValid = 1'b0;
  logic [34:0] errAddr = '0;
  logic        regSel = 1'b0, regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [28:0] logField;
  logic        logValid, firstErr, nextErr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scrub_err_logger u0 (
    .clk(clk), .pgRstN(pgRstN), .rstN(rstN), .errValid(errValid), .errAddr(errAddr),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .logField(logField), .logValid(logValid), .firstErr(firstErr), .nextErr(nextErr)
  );

  typedef struct packed {
    logic        ev;
    logic [28:0] field;
    logic        wr;
    logic [1:0]  wd;
    logic        eF;
    logic        eN;
    logic [28:0] eField;
  } vec_t;

  // Each vector: one clock edge, status writes use regSel=0
  localparam vec_t VEC [7] = '{
    '{1'b0, 29'h0,       1'b0, 2'b00, 1'b0, 1'b0, 29'h0},        // idle
    '{1'b1, 29'h0ABCDEF, 1'b0, 2'b00, 1'b1, 1'b0, 29'h0ABCDEF},  // R1 first capture
    '{1'b1, 29'h1234567, 1'b0, 2'b00, 1'b1, 1'b1, 29'h0ABCDEF},  // R2 second error
    '{1'b0, 29'h0,       1'b1, 2'b01, 1'b0, 1'b1, 29'h0ABCDEF},  // R3 clear first
    '{1'b1, 29'h0F0F0F0, 1'b0, 2'b00, 1'b1, 1'b1, 29'h0F0F0F0},  // R3 re-armed
    '{1'b1, 29'h1FFFFFF, 1'b1, 2'b01, 1'b1, 1'b1, 29'h1FFFFFF},  // R4 race
    '{1'b0, 29'h0,       1'b1, 2'b11, 1'b0, 1'b0, 29'h1FFFFFF}   // R3 clear both
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    errValid = 1'b0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] val);
    @(negedge clk);
    idle(); regSel = sel;
    @(negedge clk);
    val = regRdData;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    pgRstN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check({logField, firstErr, nextErr, logValid} == '0 && regRdData == '0, "R8 reset state",
          {logField, firstErr, nextErr, logValid}, 0);

    for (int i = 0; i < 7; i++) begin
      errValid = VEC[i].ev; errAddr = {VEC[i].field, 6'h15};
      regSel = 1'b0; regWrEn = VEC[i].wr; regWrData = {30'h3FFFFFFC, VEC[i].wd};
      @(negedge clk);
      // R1 R2 R3 R4 R9 R10: flags and field right after the sampling edge
      check(firstErr == VEC[i].eF && nextErr == VEC[i].eN && logField == VEC[i].eField
            && logValid == (VEC[i].eF | VEC[i].eN),
            $sformatf("R1,R2,R3,R4,R9,R10 vector %0d", i),
            {logField, firstErr, nextErr, logValid},
            {VEC[i].eField, VEC[i].eF, VEC[i].eN, VEC[i].eF | VEC[i].eN});
    end
    idle();

    readReg(1'b0, rd);
    check(rd == 32'h0, "R5 status read cleared", rd, 0);

    @(negedge clk);
    errValid = 1'b1; errAddr = {29'h1555AAAA, 6'h3F};
    @(negedge clk);
    idle();
    check(logValid == 1'b1, "R9 valid after error", logValid, 1);
    readReg(1'b1, rd);
    check(rd == {1'b0, 29'h1555AAAA, 2'b00}, "R5 address layout", rd, {1'b0, 29'h1555AAAA, 2'b00});
    readReg(1'b0, rd);
    check(rd == 32'h1, "R5 status layout", rd, 1);

    @(negedge clk);
    regSel = 1'b1; regWrEn = 1'b1; regWrData = 32'hFFFFFFFF;
    @(negedge clk);
    idle();
    check(logField == 29'h1555AAAA && firstErr && !nextErr, "R6 address write ignored",
          {logField, firstErr, nextErr}, {29'h1555AAAA, 2'b10});
    readReg(1'b1, rd);
    check(rd == {1'b0, 29'h1555AAAA, 2'b00}, "R6 address readback", rd, {1'b0, 29'h1555AAAA, 2'b00});

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(regRdData == 32'h0, "R7 read data cleared", regRdData, 0);
    @(negedge clk);
    rstN = 1'b1;
    check(logField == 29'h1555AAAA && firstErr && logValid, "R7 log kept over reset",
          {logField, firstErr}, {29'h1555AAAA, 1'b1});
    readReg(1'b1, rd);
    check(rd == {1'b0, 29'h1555AAAA, 2'b00}, "R7 readback after reset", rd, {1'b0, 29'h1555AAAA, 2'b00});

    @(negedge clk);
    errValid = 1'b1; errAddr = {29'h0000777, 6'h0};
    @(negedge clk);
    idle();
    check(logField == 29'h1555AAAA && nextErr, "R2 second error keeps field",
          {logField, nextErr}, {29'h1555AAAA, 1'b1});

    @(negedge clk);
    pgRstN = 1'b0; errValid = 1'b1; errAddr = {29'h1234, 6'h0};
    @(negedge clk);
    idle();
    check({logField, firstErr, nextErr, logValid} == '0 && regRdData == '0, "R8 power-good clears",
          {logField, firstErr, nextErr, regRdData}, 0);
    pgRstN = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule